// File: doc/BRIEF.md
# Heterogeneous Digit-Serial GF(2^m) Multiplier

This block multiplies two elements of a binary extension field GF(2^m). Both the field degree m (2 to 8) and the field polynomial are held in run-time registers. The work is split between two units of different width. The product unit forms the whole carry-less product of the two masked operands in a single cycle. It can also fold that product into an unreduced accumulator. The fold unit then brings the accumulator value back below degree m, a digit of `RED_DIGIT` coefficients per cycle, starting from the top coefficient.

A caller loads the field through the configuration write port while the block is idle. It then pulses `start_i` with the operands and the accumulate flag, and waits for the one-cycle `done_o` pulse. A sum of products needs only one reduction: the first product is issued with the accumulate flag low, the later ones with it high, and the result after each one is the reduced running sum.

Top module: `gfx_hetero_mul`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `result_o` are 0. The field is m = 8 with polynomial 0x11D.
- R2: With `acc_en_i` low, the result is the product a·b reduced modulo the programmed polynomial, for every m from 2 to 8.
- R3: `done_o` goes high after exactly ceil((m-1)/RED_DIGIT)+1 rising clock edges, counted from the edge that samples an accepted `start_i`. `RED_DIGIT` may only be 2 or 4.
- R4: `done_o` is high for one cycle only. `result_o` keeps its value until the next `done_o`.
- R5: With `acc_en_i` high, the unreduced product is XORed into the accumulator and the new accumulator is reduced. With `acc_en_i` low, the product replaces the accumulator. The result is therefore the reduced sum of every product since the last start with the flag low.
- R6: Operand bits at positions m and above are ignored. Result bits at positions m and above are 0.
- R7: A `start_i` while `busy_o` is high is ignored. The running operation keeps its result and its timing, and no extra `done_o` follows.
- R8: A write with `cfg_we_i` loads the degree and the polynomial only while the block is idle and only if the degree lies in 2..8. Otherwise the whole write is ignored. Polynomial bits above position m are ignored, and bit m is taken as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_deg_i | input | 4 | Field degree m to load |
| cfg_poly_i | input | 9 | Field polynomial to load, bit i is the coefficient of x^i |
| start_i | input | 1 | Start a multiplication |
| acc_en_i | input | 1 | Add the product into the accumulator instead of replacing it |
| a_i | input | 8 | Operand A |
| b_i | input | 8 | Operand B |
| busy_o | output | 1 | Reduction in progress |
| done_o | output | 1 | One-cycle pulse: result valid |
| result_o | output | 8 | Reduced result |

## Verification
A wrong digit position, shift amount or polynomial mask corrupts `result_o` at the next `done_o`, only a few cycles after the start. The exhaustive small-field sweeps expose it almost at once, because every high coefficient is hit by some operand pair. A wrong cycle counter shows as `done_o` arriving early or late against the expected count. An early pulse also leaves high coefficients unreduced, which shows as result bits at or above m. An accumulator that fails to hold or to clear shows only on the later accumulated operations, which are compared with the XOR of independent products.

// File: rtl/gfx_pkg.sv
package gfx_pkg;
  localparam int unsigned M_MAX = 8;
  localparam int unsigned PW    = 2 * M_MAX - 1;
  localparam int unsigned DW    = $clog2(M_MAX + 1);
  localparam int unsigned POS_W = $clog2(PW);

  typedef logic [M_MAX-1:0] elem_t;
  typedef logic [M_MAX:0]   poly_t;
  typedef logic [PW-1:0]    prod_t;
  typedef logic [DW-1:0]    deg_t;
  typedef logic [POS_W-1:0] pos_t;

  typedef enum logic {ST_IDLE, ST_RED} seq_st_e;
endpackage

// File: rtl/gfx_clmul.sv
// Full-width carry-less product, one cycle.
module gfx_clmul
  import gfx_pkg::*;
(
  input  elem_t a_i,
  input  elem_t b_i,
  output prod_t p_o
);
  prod_t pp [M_MAX];

  for (genvar i = 0; i < M_MAX; i++) begin : g_pp
    assign pp[i] = b_i[i] ? (prod_t'(a_i) << i) : '0;
  end

  always_comb begin
    p_o = '0;
    for (int i = 0; i < M_MAX; i++) p_o = p_o ^ pp[i];
  end
endmodule

// File: rtl/gfx_fold_step.sv
// Clears one coefficient at pos_i by adding the polynomial aligned to it.
module gfx_fold_step
  import gfx_pkg::*;
(
  input  prod_t w_i,
  input  pos_t  pos_i,
  input  logic  en_i,
  input  poly_t poly_i,
  input  deg_t  m_i,
  output prod_t w_o
);
  pos_t sh;
  assign sh  = pos_i - POS_W'(m_i);
  assign w_o = (en_i && w_i[pos_i]) ? (w_i ^ (prod_t'(poly_i) << sh)) : w_i;
endmodule

// File: rtl/gfx_red_digit.sv
// One digit of reduction: RED_DIGIT chained fold steps, top coefficient first.
module gfx_red_digit
  import gfx_pkg::*;
#(
  parameter int unsigned RED_DIGIT = 2
) (
  input  prod_t w_i,
  input  pos_t  top_i,
  input  poly_t poly_i,
  input  deg_t  m_i,
  output prod_t w_o
);
  prod_t chain [RED_DIGIT+1];
  assign chain[0] = w_i;

  for (genvar i = 0; i < RED_DIGIT; i++) begin : g_step
    logic en;
    pos_t pos;
    assign pos = top_i - POS_W'(i);
    assign en  = (int'(top_i) >= (i + int'(m_i)));
    gfx_fold_step u_step (
      .w_i   (chain[i]),
      .pos_i (pos),
      .en_i  (en),
      .poly_i(poly_i),
      .m_i   (m_i),
      .w_o   (chain[i+1])
    );
  end

  assign w_o = chain[RED_DIGIT];
endmodule

// File: rtl/gfx_seq.sv
// Sequencer: accepts start when idle, runs ceil((m-1)/D) digit cycles.
module gfx_seq
  import gfx_pkg::*;
#(
  parameter int unsigned RED_DIGIT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  deg_t m_i,
  output logic load_o,
  output logic step_o,
  output logic fin_o,
  output logic busy_o,
  output logic done_o
);
  seq_st_e st_q;
  deg_t    cnt_q;
  deg_t    ncyc;

  assign ncyc   = DW'((int'(m_i) + RED_DIGIT - 2) / RED_DIGIT);
  assign busy_o = (st_q == ST_RED);
  assign load_o = start_i && !busy_o;
  assign step_o = busy_o;
  assign fin_o  = busy_o && (cnt_q == DW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= fin_o;
      unique case (st_q)
        ST_IDLE: if (load_o) begin
          st_q  <= ST_RED;
          cnt_q <= ncyc;
        end
        ST_RED: begin
          if (fin_o) st_q <= ST_IDLE;
          cnt_q <= cnt_q - DW'(1);
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gfx_hetero_mul.sv
module gfx_hetero_mul
  import gfx_pkg::*;
#(
  parameter int unsigned RED_DIGIT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [DW-1:0]    cfg_deg_i,
  input  logic [M_MAX:0]   cfg_poly_i,
  input  logic             start_i,
  input  logic             acc_en_i,
  input  logic [M_MAX-1:0] a_i,
  input  logic [M_MAX-1:0] b_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [M_MAX-1:0] result_o
);
  if (RED_DIGIT != 2 && RED_DIGIT != 4) begin : g_bad_digit
    initial $fatal(1, "RED_DIGIT must be 2 or 4");
  end

  deg_t  m_q;
  poly_t poly_q;
  prod_t acc_q, work_q, prod, acc_nxt, red_out;
  pos_t  top_q;
  elem_t mask, result_q;
  poly_t one_sh, eff_poly;
  logic  load, step, fin, cfg_ok;

  assign one_sh   = poly_t'(1) << m_q;
  assign mask     = elem_t'(one_sh - poly_t'(1));
  assign eff_poly = (poly_q & (one_sh | (one_sh - poly_t'(1)))) | one_sh;
  assign cfg_ok   = cfg_we_i && !busy_o &&
                    (cfg_deg_i >= DW'(2)) && (cfg_deg_i <= DW'(M_MAX));

  gfx_seq #(.RED_DIGIT(RED_DIGIT)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .m_i    (m_q),
    .load_o (load),
    .step_o (step),
    .fin_o  (fin),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  gfx_clmul u_mac (
    .a_i(a_i & mask),
    .b_i(b_i & mask),
    .p_o(prod)
  );

  assign acc_nxt = acc_en_i ? (acc_q ^ prod) : prod;

  gfx_red_digit #(.RED_DIGIT(RED_DIGIT)) u_red (
    .w_i   (work_q),
    .top_i (top_q),
    .poly_i(eff_poly),
    .m_i   (m_q),
    .w_o   (red_out)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_q    <= DW'(M_MAX);
      poly_q <= poly_t'(9'h11D);
    end else if (cfg_ok) begin
      m_q    <= cfg_deg_i;
      poly_q <= cfg_poly_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      work_q   <= '0;
      top_q    <= '0;
      result_q <= '0;
    end else begin
      if (load) begin
        acc_q  <= acc_nxt;
        work_q <= acc_nxt;
        top_q  <= POS_W'({1'b0, m_q, 1'b0} - 6'd2);
      end else if (step) begin
        work_q <= red_out;
        top_q  <= top_q - POS_W'(RED_DIGIT);
      end
      if (fin) result_q <= red_out[M_MAX-1:0] & mask;
    end
  end

  assign result_o = result_q;
endmodule

// File: rtl/gfx_hetero_mul_chk.sv
module gfx_hetero_mul_chk
  import gfx_pkg::*;
#(
  parameter int unsigned RED_DIGIT = 2
) (
  input logic  clk_i,
  input logic  rst_ni,
  input logic  start_i,
  input logic  busy_o,
  input logic  done_o,
  input elem_t result_o,
  input deg_t  m_i
);
  deg_t  ncyc_q;
  logic [DW:0] lat_q;
  elem_t hi_mask;

  assign hi_mask = ~elem_t'((poly_t'(1) << m_i) - poly_t'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q  <= '0;
      ncyc_q <= '0;
    end else if (start_i && !busy_o) begin
      lat_q  <= (DW+1)'(1);
      ncyc_q <= DW'((int'(m_i) + RED_DIGIT - 2) / RED_DIGIT);
    end else if (busy_o) begin
      lat_q  <= lat_q + (DW+1)'(1);
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R4
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o)); // R4
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(busy_o) && !busy_o)); // R3
  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (lat_q == (DW+1)'(ncyc_q) + (DW+1)'(1))); // R3
  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (lat_q <= (DW+1)'(ncyc_q))); // R7
  AST_RESULT_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((result_o & hi_mask) == '0)); // R6
endmodule

bind gfx_hetero_mul gfx_hetero_mul_chk #(.RED_DIGIT(RED_DIGIT)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .result_o(result_o),
  .m_i     (m_q)
);

// File: tb/gfx_hetero_mul_tb_top.sv
module gfx_hetero_mul_tb_top;
  localparam int D = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_deg = '0;
  logic [8:0] cfg_poly = '0;
  logic       start = 1'b0;
  logic       acc_en = 1'b0;
  logic [7:0] a = '0, b = '0;
  logic       busy, done;
  logic [7:0] result;

  int n_chk = 0;
  int n_err = 0;
  int cur_m = 8;
  logic [8:0] cur_p = 9'h11D;

  always #10 clk = ~clk;

  gfx_hetero_mul #(.RED_DIGIT(D)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_deg_i(cfg_deg),
    .cfg_poly_i(cfg_poly), .start_i(start), .acc_en_i(acc_en),
    .a_i(a), .b_i(b), .busy_o(busy), .done_o(done), .result_o(result)
  );

  // Shift-and-add reference, Horner order over b.
  function automatic logic [7:0] ref_mul(logic [7:0] x, logic [7:0] y, int m, logic [8:0] p);
    logic [8:0] r = '0;
    logic [8:0] msk = (9'd1 << m) - 9'd1;
    logic [8:0] fp = (p & (msk | (9'd1 << m))) | (9'd1 << m);
    x = x & msk[7:0];
    y = y & msk[7:0];
    for (int i = m - 1; i >= 0; i--) begin
      r = r << 1;
      if (r[m]) r = r ^ fp;
      if (y[i]) r = r ^ {1'b0, x};
    end
    return r[7:0];
  endfunction

  function automatic int exp_lat(int m);
    return (m - 1 + D - 1) / D + 1;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic cfg(int m, logic [8:0] p);
    @(negedge clk);
    cfg_we = 1'b1; cfg_deg = 4'(m); cfg_poly = p;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_done(inout int lat);
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic mul(logic [7:0] x, logic [7:0] y, bit acc, output logic [7:0] r, output int lat);
    @(negedge clk);
    a = x; b = y; acc_en = acc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    wait_done(lat);
    r = result;
  endtask

  task automatic mul_chk(logic [7:0] x, logic [7:0] y, string req);
    logic [7:0] r, e;
    int lat;
    mul(x, y, 1'b0, r, lat);
    e = ref_mul(x, y, cur_m, cur_p);
    check(r == e, req, r, e);
    check(lat == exp_lat(cur_m), "R3", lat, exp_lat(cur_m));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] r, e, s;
    int lat;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 0 && done == 0 && result == 0, "R1", {busy, done, result}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0 && done == 0 && result == 0, "R1", {busy, done, result}, 0);
    // R1 default field m=8, 0x11D: x^7 * x = x^8 = 0x1D
    mul(8'h80, 8'h02, 1'b0, r, lat);
    check(r == 8'h1D, "R1", r, 8'h1D);

    // R2 GF(2^4) poly 0x13, exhaustive
    cfg(4, 9'h13); cur_m = 4; cur_p = 9'h13;
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++) mul_chk(8'(i), 8'(j), "R2");

    // R6 high operand bits ignored, result bits above m zero
    mul(8'hF3, 8'hA7, 1'b0, r, lat);
    e = ref_mul(8'h03, 8'h07, 4, 9'h13);
    check(r == e && r[7:4] == 0, "R6", r, e);

    // R4 single-cycle done, result held
    @(negedge clk);
    check(done == 0, "R4", done, 0);
    repeat (3) @(negedge clk);
    check(result == e, "R4", result, e);

    // R8 out-of-range degree write ignored entirely
    cfg(9, 9'h11D);
    mul_chk(8'h0B, 8'h0E, "R8");
    cfg(1, 9'h003);
    mul_chk(8'h09, 8'h07, "R8");
    // R8 bit m forced, bits above m ignored: 0x003 and 0x1E3 act as 0x13
    cfg(4, 9'h003);
    mul_chk(8'h0F, 8'h0D, "R8");
    cfg(4, 9'h1E3);
    mul_chk(8'h0A, 8'h0C, "R8");

    // R8 write while busy ignored
    @(negedge clk);
    a = 8'h0B; b = 8'h06; acc_en = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0; cfg_we = 1'b1; cfg_deg = 4'd8; cfg_poly = 9'h11D;
    @(negedge clk);
    cfg_we = 1'b0;
    lat = 2;
    wait_done(lat);
    e = ref_mul(8'h0B, 8'h06, 4, 9'h13);
    check(result == e, "R8", result, e);
    mul_chk(8'h07, 8'h0E, "R8");

    // R7 start while busy ignored (m=8 for a long reduction)
    cfg(8, 9'h11D); cur_m = 8; cur_p = 9'h11D;
    @(negedge clk);
    a = 8'hC3; b = 8'h5A; acc_en = 1'b0; start = 1'b1;
    @(negedge clk);
    a = 8'h11; b = 8'h22; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 2;
    wait_done(lat);
    e = ref_mul(8'hC3, 8'h5A, 8, 9'h11D);
    check(result == e, "R7", result, e);
    check(lat == exp_lat(8), "R7", lat, exp_lat(8));
    lat = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (done || busy) lat++;
    end
    check(lat == 0, "R7", lat, 0);

    // R5 accumulate: sum of products with one reduction each step
    mul(8'h57, 8'h83, 1'b0, r, lat);
    s = ref_mul(8'h57, 8'h83, 8, 9'h11D);
    check(r == s, "R5", r, s);
    mul(8'hA1, 8'h3C, 1'b1, r, lat);
    s = s ^ ref_mul(8'hA1, 8'h3C, 8, 9'h11D);
    check(r == s, "R5", r, s);
    mul(8'hFF, 8'hFE, 1'b1, r, lat);
    s = s ^ ref_mul(8'hFF, 8'hFE, 8, 9'h11D);
    check(r == s, "R5", r, s);
    mul(8'h12, 8'h34, 1'b0, r, lat);
    e = ref_mul(8'h12, 8'h34, 8, 9'h11D);
    check(r == e, "R5", r, e);

    // R2 GF(2^8) 0x11D near-exhaustive sweep
    for (int i = 0; i < 256; i++) begin
      mul_chk(8'(i), 8'h02, "R2");
      mul_chk(8'(i), 8'h53, "R2");
      mul_chk(8'(i), 8'hFF, "R2");
      mul_chk(8'(i), 8'(i) ^ 8'h5C, "R2");
    end

    // R2 other degrees
    cfg(3, 9'h0B); cur_m = 3; cur_p = 9'h0B;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) mul_chk(8'(i), 8'(j), "R2");
    cfg(2, 9'h07); cur_m = 2; cur_p = 9'h07;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) mul_chk(8'(i), 8'(j), "R2");
    cfg(5, 9'h25); cur_m = 5; cur_p = 9'h25;
    for (int i = 0; i < 32; i++) mul_chk(8'(i), 8'h1B, "R2");
    cfg(6, 9'h43); cur_m = 6; cur_p = 9'h43;
    for (int i = 0; i < 64; i++) mul_chk(8'(i), 8'h2D, "R2");
    cfg(7, 9'h89); cur_m = 7; cur_p = 9'h89;
    for (int i = 0; i < 128; i++) mul_chk(8'(i), 8'h71, "R2");

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule